// File: doc/BRIEF.md
# Dual-Port Word Memory with Cross-Port Mailbox Interrupts

This block is a synchronous two-port word memory. A left port and a right port each reach every word on their own: each can read or write any address in any cycle, with per-byte write control and its own registered read path. Each port has a chip enable, a read/write select, an output enable, two byte-lane enables, an address, a write-data bus and a read-data bus with a read-valid flag.

The two highest words double as mailboxes for messages between the ports. The topmost word belongs to the right port and the word just below it belongs to the left port. When one port writes the other port's mailbox, the owner's active-low interrupt flag goes low. The flag stays low until the owner reads its own mailbox. The depth is set by `ADDR_W`. The value 14 gives the full 16K-word array. The default of 10 keeps elaboration small, so the mailboxes sit at 0x3FF and 0x3FE.

The ports never stall. There is no ready signal and no back-pressure. An access is accepted in the cycle its chip enable is high, and read data follows exactly one cycle later. Accesses from both ports to one ordinary address in the same cycle are left to an external busy arbiter. This block still gives them a fixed, defined outcome.

Top module: `dpram_mailbox`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both interrupt outputs are high, both read-valid outputs are 0 and both read-data buses are zero.
- R2: A read access is chip enable 1 with read/write select 0. A read access with output enable 1 presents the addressed word on that port's read-data bus, with read-valid 1, in the next cycle. A write with chip enable 1 and read/write select 1 is visible to later reads from either port.
- R3: On a write, high-lane enable 1 writes bits 15:8 and low-lane enable 1 writes bits 7:0. A lane whose enable is 0 keeps its old contents. A write with both enables 0 changes nothing.
- R4: In the cycle after a cycle with no read access, or a read access with output enable 0, the port's read-valid is 0 and its read-data bus is all zeros.
- R5: A left-port write to address all-ones (the right mailbox) with at least one lane enabled drives `r_irq_n` low in the next cycle. A right-port write to address all-ones minus one (the left mailbox) drives `l_irq_n` low in the next cycle.
- R6: A read access by a port to its own mailbox returns `*_irq_n` to high in the next cycle. This holds whatever the output enable is.
- R7: A read of the other port's mailbox returns its contents and leaves that port's interrupt unchanged.
- R8: If a mailbox write from the other port and the owner's read of that mailbox fall in the same cycle, the interrupt is low in the next cycle. The read returns the word held before the write.
- R9: A port writing its own mailbox does not change either interrupt.
- R10: Accesses to one address from both ports in the same cycle behave as follows. A read returns the word held before the cycle. If both ports write the same lane, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_ce | input | 1 | Left chip enable |
| l_we | input | 1 | Left read/write select, 1 = write |
| l_oe | input | 1 | Left output enable |
| l_hi_en | input | 1 | Left high byte-lane enable |
| l_lo_en | input | 1 | Left low byte-lane enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_ce | input | 1 | Right chip enable |
| r_we | input | 1 | Right read/write select, 1 = write |
| r_oe | input | 1 | Right output enable |
| r_hi_en | input | 1 | Right high byte-lane enable |
| r_lo_en | input | 1 | Right low byte-lane enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The bench targets the mailbox corners. It covers an owner read that coincides with a fresh write, which a clear-priority design would lose. It covers a peek at the other side's mailbox, which a design decoding only the address would wrongly clear. It covers a port posting to its own mailbox, which a side-blind decoder would flag. It also covers an owner read with output enable low, which a design tying the clear to the data path would miss. Byte-lane writes with one or no lane enabled expose lane swaps or whole-word writes. Same-cycle read/write and write/write to one address expose a wrong read-before-write order or a wrong write priority. A random phase near the top of memory mixes all of these.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  typedef struct packed {
    logic ce;
    logic we;
    logic oe;
    logic hi;
    logic lo;
  } port_ctl_t;

  function automatic logic is_read(port_ctl_t c);
    return c.ce & ~c.we;
  endfunction

  function automatic logic [1:0] write_lanes(port_ctl_t c);
    return {2{c.ce & c.we}} & {c.hi, c.lo};
  endfunction

endpackage

// File: rtl/dpm_mem.sv
module dpm_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [1:0]        a_wlane,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_rd,
  output logic [DATA_W-1:0] a_word,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [1:0]        b_wlane,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_rd,
  output logic [DATA_W-1:0] b_word
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] a_q, b_q;

  // Reads sample the array before this edge's writes land; port a is
  // written last so it takes precedence on a shared lane.
  always_ff @(posedge clk) begin
    if (a_rd) a_q <= mem[a_addr];
    if (b_rd) b_q <= mem[b_addr];
    for (int k = 0; k < 2; k++) begin
      if (b_wlane[k]) mem[b_addr][k*LANE_W +: LANE_W] <= b_wdata[k*LANE_W +: LANE_W];
    end
    for (int k = 0; k < 2; k++) begin
      if (a_wlane[k]) mem[a_addr][k*LANE_W +: LANE_W] <= a_wdata[k*LANE_W +: LANE_W];
    end
  end

  assign a_word = a_q;
  assign b_word = b_q;
endmodule

// File: rtl/dpm_rdport.sv
module dpm_rdport #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  logic              oe,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_acc & oe;
  end

  assign rvalid = vld_q;
  assign rdata  = vld_q ? raw : '0;
endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic post,
  input  logic take,
  output logic irq_n
);
  logic pend_q;

  // A post in the same cycle as a take leaves the flag pending.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= 1'b0;
    else if (post) pend_q <= 1'b1;
    else if (take) pend_q <= 1'b0;
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_hi_en,
  input  logic              l_lo_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_irq_n,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_hi_en,
  input  logic              r_lo_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_irq_n
);
  import dpm_pkg::*;

  localparam logic [ADDR_W-1:0] MBOX_R = '1;
  localparam logic [ADDR_W-1:0] MBOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};

  port_ctl_t         l_ctl, r_ctl;
  logic [1:0]        l_lanes, r_lanes;
  logic              l_rd, r_rd;
  logic [DATA_W-1:0] l_word, r_word;

  assign l_ctl = '{ce: l_ce, we: l_we, oe: l_oe, hi: l_hi_en, lo: l_lo_en};
  assign r_ctl = '{ce: r_ce, we: r_we, oe: r_oe, hi: r_hi_en, lo: r_lo_en};

  assign l_lanes = write_lanes(l_ctl);
  assign r_lanes = write_lanes(r_ctl);
  assign l_rd    = is_read(l_ctl);
  assign r_rd    = is_read(r_ctl);

  dpm_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk    (clk),
    .a_addr (l_addr),
    .a_wlane(l_lanes),
    .a_wdata(l_wdata),
    .a_rd   (l_rd),
    .a_word (l_word),
    .b_addr (r_addr),
    .b_wlane(r_lanes),
    .b_wdata(r_wdata),
    .b_rd   (r_rd),
    .b_word (r_word)
  );

  dpm_rdport #(.DATA_W(DATA_W)) l_out_i (
    .clk(clk), .rst_n(rst_n), .rd_acc(l_rd), .oe(l_oe),
    .raw(l_word), .rdata(l_rdata), .rvalid(l_rvalid)
  );

  dpm_rdport #(.DATA_W(DATA_W)) r_out_i (
    .clk(clk), .rst_n(rst_n), .rd_acc(r_rd), .oe(r_oe),
    .raw(r_word), .rdata(r_rdata), .rvalid(r_rvalid)
  );

  // Interrupt posted by the opposite side, taken by the owner's read.
  logic post_l, take_l, post_r, take_r;
  assign post_r = (|l_lanes) && (l_addr == MBOX_R);
  assign take_r = r_rd && (r_addr == MBOX_R);
  assign post_l = (|r_lanes) && (r_addr == MBOX_L);
  assign take_l = l_rd && (l_addr == MBOX_L);

  dpm_irq_flag l_irq_i (
    .clk(clk), .rst_n(rst_n), .post(post_l), .take(take_l), .irq_n(l_irq_n)
  );

  dpm_irq_flag r_irq_i (
    .clk(clk), .rst_n(rst_n), .post(post_r), .take(take_r), .irq_n(r_irq_n)
  );
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_ce,
  input logic              l_we,
  input logic              l_oe,
  input logic              l_hi_en,
  input logic              l_lo_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_rvalid,
  input logic              l_irq_n,
  input logic              r_ce,
  input logic              r_we,
  input logic              r_oe,
  input logic              r_hi_en,
  input logic              r_lo_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_wdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_rvalid,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP  = '1;
  localparam logic [ADDR_W-1:0] TOP1 = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic l_wr_top, r_wr_top1, r_rd_top, l_rd_top1, l_rd_oe, r_rd_oe;
  assign l_wr_top  = l_ce && l_we && (l_hi_en || l_lo_en) && (l_addr == TOP);
  assign r_wr_top1 = r_ce && r_we && (r_hi_en || r_lo_en) && (r_addr == TOP1);
  assign r_rd_top  = r_ce && !r_we && (r_addr == TOP);
  assign l_rd_top1 = l_ce && !l_we && (l_addr == TOP1);
  assign l_rd_oe   = l_ce && !l_we && l_oe;
  assign r_rd_oe   = r_ce && !r_we && r_oe;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (l_irq_n && r_irq_n && !l_rvalid && !r_rvalid));

  p_l_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    l_rd_oe |=> l_rvalid);
  p_r_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    r_rd_oe |=> r_rvalid);

  p_l_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd_oe |=> (!l_rvalid && l_rdata == '0));
  p_r_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd_oe |=> (!r_rvalid && r_rdata == '0));

  p_r_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
    l_wr_top |=> !r_irq_n);
  p_l_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
    r_wr_top1 |=> !l_irq_n);

  p_r_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd_top && !l_wr_top) |=> r_irq_n);
  p_l_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd_top1 && !r_wr_top1) |=> l_irq_n);

  p_r_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_irq_n && !r_rd_top) |=> !r_irq_n);
  p_l_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_irq_n && !l_rd_top1) |=> !l_irq_n);

  p_r_post_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr_top && r_rd_top) |=> !r_irq_n);

  p_r_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_irq_n && !l_wr_top) |=> r_irq_n);
  p_l_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (l_irq_n && !r_wr_top1) |=> l_irq_n);
endmodule

bind dpram_mailbox dpm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/dpram_mailbox_tb.sv
module dpram_mailbox_tb_top;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOP  = '1;
  localparam logic [AW-1:0] TOP1 = TOP - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce, l_we, l_oe, l_hi_en, l_lo_en, r_ce, r_we, r_oe, r_hi_en, r_lo_en;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_irq_n, r_irq_n;

  always #5 clk = ~clk;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  // reference model state
  logic [DW-1:0] mm [DEPTH];
  logic [DW-1:0] e_l_rd, e_r_rd;
  logic e_l_rv, e_r_rv, e_l_pend, e_r_pend;
  int n_chk = 0, n_fail = 0, cyc = 0;
  string req = "R1";

  task automatic check(string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    l_ce = 0; l_we = 0; l_oe = 0; l_hi_en = 0; l_lo_en = 0; l_addr = '0; l_wdata = '0;
    r_ce = 0; r_we = 0; r_oe = 0; r_hi_en = 0; r_lo_en = 0; r_addr = '0; r_wdata = '0;
  endtask

  task automatic lw(logic [AW-1:0] a, logic [DW-1:0] d, logic hi = 1, logic lo = 1);
    l_ce = 1; l_we = 1; l_addr = a; l_wdata = d; l_hi_en = hi; l_lo_en = lo;
  endtask
  task automatic rw(logic [AW-1:0] a, logic [DW-1:0] d, logic hi = 1, logic lo = 1);
    r_ce = 1; r_we = 1; r_addr = a; r_wdata = d; r_hi_en = hi; r_lo_en = lo;
  endtask
  task automatic lr(logic [AW-1:0] a, logic oe = 1);
    l_ce = 1; l_we = 0; l_addr = a; l_oe = oe;
  endtask
  task automatic rr(logic [AW-1:0] a, logic oe = 1);
    r_ce = 1; r_we = 0; r_addr = a; r_oe = oe;
  endtask

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, logic hi, logic lo);
    logic [DW-1:0] v = old;
    if (hi) v[15:8] = d[15:8];
    if (lo) v[7:0] = d[7:0];
    return v;
  endfunction

  // One clock: model updates from the inputs held over the edge,
  // outputs compared at the following falling edge.
  task automatic step();
    logic l_rdacc, r_rdacc, l_wr, r_wr;
    @(posedge clk);
    cyc++;
    l_rdacc = l_ce && !l_we;
    r_rdacc = r_ce && !r_we;
    l_wr = l_ce && l_we && (l_hi_en || l_lo_en);
    r_wr = r_ce && r_we && (r_hi_en || r_lo_en);
    e_l_rv = l_rdacc && l_oe;
    e_r_rv = r_rdacc && r_oe;
    e_l_rd = e_l_rv ? mm[l_addr] : '0;
    e_r_rd = e_r_rv ? mm[r_addr] : '0;
    if (r_wr) mm[r_addr] = merge(mm[r_addr], r_wdata, r_hi_en, r_lo_en);
    if (l_wr) mm[l_addr] = merge(mm[l_addr], l_wdata, l_hi_en, l_lo_en);
    if (l_wr && l_addr == TOP) e_r_pend = 1;
    else if (r_rdacc && r_addr == TOP) e_r_pend = 0;
    if (r_wr && r_addr == TOP1) e_l_pend = 1;
    else if (l_rdacc && l_addr == TOP1) e_l_pend = 0;
    @(negedge clk);
    check("l_rdata", l_rdata, e_l_rd);
    check("l_rvalid", {15'b0, l_rvalid}, {15'b0, e_l_rv});
    check("r_rdata", r_rdata, e_r_rd);
    check("r_rvalid", {15'b0, r_rvalid}, {15'b0, e_r_rv});
    check("l_irq_n", {15'b0, l_irq_n}, {15'b0, ~e_l_pend});
    check("r_irq_n", {15'b0, r_irq_n}, {15'b0, ~e_r_pend});
    idle();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    idle();
    e_l_rv = 0; e_r_rv = 0; e_l_rd = '0; e_r_rd = '0; e_l_pend = 0; e_r_pend = 0;
    // R1: reset values
    req = "R1";
    repeat (3) @(negedge clk);
    check("l_irq_n", {15'b0, l_irq_n}, 16'd1);
    check("r_irq_n", {15'b0, r_irq_n}, 16'd1);
    check("l_rvalid", {15'b0, l_rvalid}, 16'd0);
    check("r_rdata", r_rdata, 16'd0);
    rst_n = 1;
    step();

    // R2: preload, left writes 0..TOP1 (own mailbox at TOP1), right writes TOP
    req = "R2";
    for (int i = 0; i < DEPTH - 1; i++) begin
      lw(AW'(i), DW'(i * 16'h9e37) ^ 16'h5a5a);
      step();
    end
    rw(TOP, 16'h7001); step();
    lr(AW'(5)); rr(AW'(700)); step();
    lr(AW'(0)); rr(AW'(1)); step();
    rw(AW'(33), 16'hbeef); step();
    lr(AW'(33)); step();
    step();

    // R3: byte lanes
    req = "R3";
    lw(AW'(40), 16'h1234); step();
    lw(AW'(40), 16'hab99, 1, 0); step();
    rr(AW'(40)); step();
    rw(AW'(40), 16'h77cd, 0, 1); step();
    lr(AW'(40)); step();
    lw(AW'(40), 16'hffff, 0, 0); step();
    rr(AW'(40)); step();

    // R4: output enable low, chip disabled, writes produce no read data
    req = "R4";
    lr(AW'(40), 0); rr(AW'(41), 0); step();
    l_we = 0; l_oe = 1; l_addr = AW'(40); step();
    lw(AW'(42), 16'h4242); r_oe = 1; step();
    step();

    // R5: mailbox posts
    req = "R5";
    lw(TOP, 16'hc0de); step();
    rw(TOP1, 16'hfeed); step();
    step();

    // R7: peeking at the other side's mailbox
    req = "R7";
    lr(TOP); rr(TOP1); step();
    step();

    // R6: owner reads clear, right with output enable low
    req = "R6";
    rr(TOP, 0); step();
    lr(TOP1); step();
    step();

    // R8: post and take in the same cycle
    req = "R8";
    lw(TOP, 16'h0bad); rr(TOP); step();
    step();
    rr(TOP); step();
    rw(TOP1, 16'h1111); lr(TOP1); step();
    lr(TOP1); step();

    // R9: writing one's own mailbox
    req = "R9";
    rw(TOP, 16'h2222); step();
    lw(TOP1, 16'h3333, 1, 0); step();
    lr(TOP1); rr(TOP); step();
    lw(TOP, 16'h4444, 0, 0); step();

    // R10: same-address collisions
    req = "R10";
    lw(AW'(60), 16'haaaa); rr(AW'(60)); step();
    rw(AW'(60), 16'h5555); lr(AW'(60)); step();
    lw(AW'(61), 16'h1111); rw(AW'(61), 16'h2222); step();
    lw(AW'(62), 16'h00aa, 0, 1); rw(AW'(62), 16'hbb00, 1, 0); step();
    lr(AW'(61)); rr(AW'(62)); step();
    step();

    // random mix near the top of memory
    req = "R2";
    for (int i = 0; i < 3000; i++) begin
      l_ce = $urandom_range(0, 3) != 0; l_we = $urandom_range(0, 1) == 1;
      l_oe = $urandom_range(0, 3) != 0; l_hi_en = $urandom_range(0, 1) == 1;
      l_lo_en = $urandom_range(0, 1) == 1; l_addr = TOP - AW'($urandom_range(0, 5));
      l_wdata = DW'($urandom);
      r_ce = $urandom_range(0, 3) != 0; r_we = $urandom_range(0, 1) == 1;
      r_oe = $urandom_range(0, 3) != 0; r_hi_en = $urandom_range(0, 1) == 1;
      r_lo_en = $urandom_range(0, 1) == 1; r_addr = TOP - AW'($urandom_range(0, 5));
      r_wdata = DW'($urandom);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule